// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two numbers held in signed-magnitude form. Each operand is a sign bit plus an unsigned magnitude of `MAG_W` bits. A mode input picks addition or subtraction. A subtraction is turned into an addition by flipping the sign of the second operand.

The unit then compares the two effective signs. When they agree, it adds the magnitudes and keeps the first operand's sign, and the carry out of the top bit becomes the overflow flag. When they differ, it forms first plus the one's complement of second plus one. The carry out of that sum then settles the result. A carry means the first magnitude was at least as large, so the difference is kept. No carry means the first magnitude was smaller, so the difference is two's-complemented and the sign is flipped. A zero difference is always reported as positive zero.

The operation is started with a one-cycle request. The unit loads the operands into its own registers, then runs an add step and a correction step. It answers with a one-cycle completion pulse. The result sign, magnitude and overflow flag then stay put until the next accepted request.

Top module: `sm_addsub_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released, `done`, `res_sign`, `res_mag` and `add_ovf` are all 0.
- R2: When `sub_mode` is 1, the unit treats the operation as an addition with the inverse of `b_sign`. When `sub_mode` is 0, it uses `b_sign` unchanged.
- R3: When the effective signs are equal, `res_mag` = (`a_mag` + `b_mag`) mod 2^MAG_W and `res_sign` = `a_sign`, even when both magnitudes are zero.
- R4: When the effective signs are equal, `add_ovf` is 1 exactly when `a_mag` + `b_mag` ≥ 2^MAG_W.
- R5: When the effective signs differ, `add_ovf` is 0.
- R6: When the effective signs differ and `a_mag` > `b_mag`, `res_mag` = `a_mag` − `b_mag` and `res_sign` = `a_sign`.
- R7: When the effective signs differ and `a_mag` = `b_mag`, `res_mag` = 0 and `res_sign` = 0 (positive zero).
- R8: When the effective signs differ and `a_mag` < `b_mag`, `res_mag` = `b_mag` − `a_mag` and `res_sign` is the inverse of `a_sign`.
- R9: A `start` sampled high while idle produces a `done` pulse exactly one cycle wide. The pulse is high in the third cycle after the cycle in which `start` was sampled. The outputs hold the final result while `done` is high.
- R10: After `done`, the outputs `res_sign`, `res_mag` and `add_ovf` hold their values until the next accepted `start`.
- R11: A `start` that arrives while an operation is in progress is ignored. It does not change the result and does not add a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one operation (sampled only while idle) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | MAG_W | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand (1 = negative) |
| b_mag | input | MAG_W | Magnitude of second operand |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | Result sign |
| res_mag | output | MAG_W | Result magnitude |
| add_ovf | output | 1 | Add-path overflow flag |

## Verification
Some internal faults leave a stale value behind. A stale end carry, a wrong path-select bit, or a correction applied on the wrong branch all show up at the ports in the same cycle that `done` rises. They appear as a wrong magnitude or sign in one of the three subtract-path branches, or as a wrong overflow flag on the add path. A sweep over every sign, magnitude and mode combination therefore exposes such a fault within four cycles of the request that triggers it.

Sequencing faults show up differently. A premature or doubled `done`, or a result that drifts while idle, becomes visible in the cycles just around the pulse. Each of those cycles is sampled.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_FIX  = 2'd2
  } sm_state_e;
endpackage

// File: rtl/sm_sign_select.sv
// Decides between the magnitude-add and magnitude-subtract paths.
module sm_sign_select (
  input  logic a_sign,
  input  logic b_sign,
  input  logic sub_mode,
  output logic sub_path
);
  logic b_eff;

  always_comb begin
    b_eff    = b_sign ^ sub_mode;   // subtract: flip the second sign
    sub_path = a_sign ^ b_eff;      // unlike signs: subtract magnitudes
  end
endmodule

// File: rtl/sm_mag_adder.sv
// Complementer plus parallel adder with an end carry.
module sm_mag_adder #(
  parameter int MAG_W = 4
) (
  input  logic [MAG_W-1:0] a_in,
  input  logic [MAG_W-1:0] b_in,
  input  logic             complement,
  output logic             carry,
  output logic [MAG_W-1:0] sum
);
  logic [MAG_W-1:0] b_cx;
  logic [MAG_W:0]   total;

  for (genvar i = 0; i < MAG_W; i++) begin : g_cpl
    assign b_cx[i] = b_in[i] ^ complement;
  end

  always_comb begin
    total = {1'b0, a_in} + {1'b0, b_cx} + {{MAG_W{1'b0}}, complement};
    carry = total[MAG_W];
    sum   = total[MAG_W-1:0];
  end
endmodule

// File: rtl/sm_result_fix.sv
// Fixes magnitude and sign after the adder step.
module sm_result_fix #(
  parameter int MAG_W = 4
) (
  input  logic             sub_path,
  input  logic             end_carry,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] mag_in,
  output logic             sign_out,
  output logic [MAG_W-1:0] mag_out
);
  always_comb begin
    mag_out  = mag_in;
    sign_out = a_sign;
    if (sub_path) begin
      if (end_carry) begin
        if (mag_in == '0) sign_out = 1'b0;     // equal magnitudes: +0
      end else begin
        mag_out  = ~mag_in + {{(MAG_W-1){1'b0}}, 1'b1};
        sign_out = ~a_sign;
      end
    end
  end
endmodule

// File: rtl/sm_addsub_unit.sv
module sm_addsub_unit #(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sub_mode,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             done,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             add_ovf
);
  import sm_pkg::*;

  sm_state_e        st;
  logic [MAG_W-1:0] acc_q;
  logic [MAG_W-1:0] opb_q;
  logic             asg_q;
  logic             bsg_q;
  logic             mode_q;
  logic             e_q;
  logic             ovf_q;
  logic             path_q;
  logic             done_q;

  logic             sub_path_c;
  logic             carry_c;
  logic [MAG_W-1:0] sum_c;
  logic             fix_sign_c;
  logic [MAG_W-1:0] fix_mag_c;

  sm_sign_select u_sel (
    .a_sign   (asg_q),
    .b_sign   (bsg_q),
    .sub_mode (mode_q),
    .sub_path (sub_path_c)
  );

  sm_mag_adder #(.MAG_W(MAG_W)) u_add (
    .a_in       (acc_q),
    .b_in       (opb_q),
    .complement (sub_path_c),
    .carry      (carry_c),
    .sum        (sum_c)
  );

  sm_result_fix #(.MAG_W(MAG_W)) u_fix (
    .sub_path  (path_q),
    .end_carry (e_q),
    .a_sign    (asg_q),
    .mag_in    (acc_q),
    .sign_out  (fix_sign_c),
    .mag_out   (fix_mag_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      acc_q  <= '0;
      opb_q  <= '0;
      asg_q  <= 1'b0;
      bsg_q  <= 1'b0;
      mode_q <= 1'b0;
      e_q    <= 1'b0;
      ovf_q  <= 1'b0;
      path_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            acc_q  <= a_mag;
            asg_q  <= a_sign;
            opb_q  <= b_mag;
            bsg_q  <= b_sign;
            mode_q <= sub_mode;
            st     <= ST_ADD;
          end
        end
        ST_ADD: begin
          acc_q  <= sum_c;
          e_q    <= carry_c;
          path_q <= sub_path_c;
          ovf_q  <= sub_path_c ? 1'b0 : carry_c;
          st     <= ST_FIX;
        end
        ST_FIX: begin
          acc_q  <= fix_mag_c;
          asg_q  <= fix_sign_c;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign res_sign = asg_q;
  assign res_mag  = acc_q;
  assign add_ovf  = ovf_q;
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             idle,
  input logic             sub_path,
  input logic             done,
  input logic             res_sign,
  input logic [MAG_W-1:0] res_mag,
  input logic             add_ovf
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                     // R9

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!idle));                                              // R9

  AST_SUB_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && sub_path) |-> !add_ovf);                                    // R5

  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (done && sub_path && res_mag == '0) |-> !res_sign);                  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> ($stable(res_mag) && $stable(res_sign) && $stable(add_ovf))); // R10
endmodule

bind sm_addsub_unit sm_addsub_chk #(.MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .idle     (st == sm_pkg::ST_IDLE),
  .sub_path (path_q),
  .done     (done),
  .res_sign (res_sign),
  .res_mag  (res_mag),
  .add_ovf  (add_ovf)
);

// File: tb/test_sm_addsub_unit.sv
module test_sm_addsub_unit;
  localparam int W    = 4;
  localparam int MAXV = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         sub_mode = 1'b0;
  logic         a_sign = 1'b0;
  logic [W-1:0] a_mag = '0;
  logic         b_sign = 1'b0;
  logic [W-1:0] b_mag = '0;
  logic         done;
  logic         res_sign;
  logic [W-1:0] res_mag;
  logic         add_ovf;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sm_addsub_unit #(.MAG_W(W)) i_sm_addsub_unit (
    .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .done(done), .res_sign(res_sign), .res_mag(res_mag), .add_ovf(add_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pack_res(input int ovf, input int sg, input int mg);
    return ovf * 1000 + sg * 100 + mg;
  endfunction

  // One operation; poke=1 raises start again mid-operation with other operands.
  task automatic run_op(input int sm, input int as, input int am,
                        input int bs, input int bm, input bit poke);
    int bse, exp_m, exp_s, exp_o, act;
    string tag;
    bse = bs ^ sm;
    if (as == bse) begin
      exp_m = (am + bm) % MAXV;
      exp_s = as;
      exp_o = (am + bm >= MAXV) ? 1 : 0;
      tag   = exp_o ? "R4" : "R3";
    end else begin
      exp_o = 0;
      if (am > bm)       begin exp_m = am - bm; exp_s = as;     tag = "R6"; end
      else if (am == bm) begin exp_m = 0;       exp_s = 0;      tag = "R7"; end
      else               begin exp_m = bm - am; exp_s = 1 - as; tag = "R8"; end
    end
    if (sm == 1) tag = {"R2 ", tag};
    if (as != bse) tag = {tag, " R5"};

    @(negedge clk);
    sub_mode = sm[0]; a_sign = as[0]; a_mag = am[W-1:0];
    b_sign = bs[0];   b_mag = bm[W-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done early (cycle 1)", int'(done), 0);
    if (poke) begin
      start = 1'b1; a_mag = ~a_mag; b_mag = b_mag + 4'd3;
      a_sign = ~a_sign; sub_mode = ~sub_mode;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done early (cycle 2)", int'(done), 0);
    @(negedge clk);
    chk("R9", "done missing (cycle 3)", int'(done), 1);
    act = pack_res(int'(add_ovf), int'(res_sign), int'(res_mag));
    chk(poke ? {tag, " R11"} : tag, $sformatf("sm=%0d a=%0d/%0d b=%0d/%0d", sm, as, am, bs, bm),
        act, pack_res(exp_o, exp_s, exp_m));
    @(negedge clk);
    chk(poke ? "R9 R11" : "R9", "done not single", int'(done), 0);
    chk("R10", "result not held", pack_res(int'(add_ovf), int'(res_sign), int'(res_mag)), act);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", pack_res(int'(add_ovf), int'(res_sign), int'(res_mag)) + 10000 * int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset outputs", pack_res(int'(add_ovf), int'(res_sign), int'(res_mag)) + 10000 * int'(done), 0);

    for (int sm = 0; sm < 2; sm++)
      for (int as = 0; as < 2; as++)
        for (int bs = 0; bs < 2; bs++)
          for (int am = 0; am < MAXV; am++)
            for (int bm = 0; bm < MAXV; bm++)
              run_op(sm, as, am, bs, bm, (am == 5) && (bm % 3 == 0));

    // Idle hold over several cycles with inputs changing
    @(negedge clk);
    begin
      int held;
      held = pack_res(int'(add_ovf), int'(res_sign), int'(res_mag));
      a_mag = 4'd9; b_mag = 4'd2; a_sign = 1'b1; sub_mode = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10", "idle drift", pack_res(int'(add_ovf), int'(res_sign), int'(res_mag)), held);
      chk("R9", "spurious done while idle", int'(done), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule